// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block decides which operating mode a CAN protocol controller is in: running, asleep, debug-frozen, or in the single cycle of a master reset. Software drives it through a small control register that holds a sleep request, an automatic wake enable, a debug freeze enable and a self-clearing master reset bit. A debug halt input, a frame-in-progress flag from the protocol engine and the raw receive line complete the inputs.

The outputs are a mode code, a sleep acknowledge, a freeze signal that stops the transmit and receive engines, and a one-cycle control reset that the surrounding logic uses to clear the receive FIFO pending counts. A release strobe for the receive FIFOs passes through the block. It is blocked only during the reset cycle, so software can still drain the FIFOs while traffic is frozen. Receive-line activity is brought into the clock domain by a synchronizer. A falling edge, recessive (1) to dominant (0), counts as a message start for automatic wake.

The states are MRESET, SLEEP, SLEEP_WAIT, NORMAL and FROZEN. The transitions are:
- A master reset write moves any state to MRESET.
- MRESET moves to SLEEP.
- SLEEP moves to NORMAL when the sleep request is cleared, or when a wake edge arrives while automatic wake is enabled.
- NORMAL moves to SLEEP_WAIT on a sleep request, or to FROZEN when a debug halt arrives with freeze enabled.
- SLEEP_WAIT moves to SLEEP once no frame is in progress, or back to NORMAL if the request is withdrawn.
- FROZEN moves to NORMAL when the halt ends or freeze is disabled.

Top module: `canmode_ctrl`

## Requirements
- R1: A write with control bit 3 set moves the block to MRESET on the next edge. In MRESET, mode reads 2'b11 and ctl_rst is high for exactly one cycle. The block then enters SLEEP (mode 2'b01, sleep_ack 1) with control bits [2:0] back at 3'b001.
- R2: Control bit 3 reads 1 only during the MRESET cycle and reads 0 afterwards, without any write from software.
- R3: With control bit 2 (freeze enable) set and dbg_halt high, the block leaves NORMAL for FROZEN. In FROZEN, mode reads 2'b10 and eng_freeze is 1. It returns to NORMAL when dbg_halt falls.
- R4: While frozen, fifo_rel_go follows fifo_rel_req.
- R5: With freeze enable clear, dbg_halt has no effect: the mode stays NORMAL and eng_freeze stays 0.
- R6: With control bit 1 (automatic wake) clear, receive-line edges do not end SLEEP. Only clearing control bit 0 (sleep request) moves the block to NORMAL.
- R7: With automatic wake set, a 1-to-0 edge on rx_line during SLEEP moves the block to NORMAL within three cycles. Hardware clears control bit 0 and sleep_ack.
- R8: After a sleep request from NORMAL, mode stays 2'b00 and sleep_ack stays 0 while frame_busy is high. sleep_ack rises on the edge after frame_busy goes low.
- R9: Control bits above bit 3 always read 0 and ignore written values.
- R10: After power-on reset the block is in SLEEP, with sleep_ack 1, eng_freeze 0 and control bits reading 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Write data: bit0 sleep request, bit1 automatic wake, bit2 freeze enable, bit3 master reset |
| cfg_rdata | output | CFG_W | Control register read value |
| dbg_halt | input | 1 | Debug halt from the system |
| frame_busy | input | 1 | Protocol engine has a frame in progress |
| rx_line | input | 1 | Raw receive line, 1 recessive |
| fifo_rel_req | input | 1 | Software release request for a receive FIFO |
| fifo_rel_go | output | 1 | Release passed to the FIFOs |
| mode | output | 2 | 00 normal, 01 sleep, 10 frozen, 11 resetting |
| sleep_ack | output | 1 | Sleep acknowledge |
| eng_freeze | output | 1 | Stops the transmit and receive engines |
| ctl_rst | output | 1 | One-cycle reset for control settings and FIFO pending counts |

## Verification
The hardest situation to reach is the hardware wake. It needs the sleep request and automatic wake set together while the block sits in SLEEP, followed by a falling receive edge that has been held long enough to cross the synchronizer. The stimulus table first rests in SLEEP with automatic wake off and holds the line dominant, then restores the line to recessive while enabling automatic wake so that no stale edge exists. Only then does it drop the line, and it checks that the sleep request bit was cleared by hardware. The master reset is checked cycle by cycle so that the single MRESET cycle and the self-clearing bit are both seen.

// File: rtl/canmode_pkg.sv
package canmode_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_NORMAL,
        ST_SLEEP_WAIT,
        ST_FROZEN,
        ST_MRESET
    } ctl_state_t;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_SLEEP  = 2'b01,
        MODE_FROZEN = 2'b10,
        MODE_RESET  = 2'b11
    } mode_code_t;

    localparam int BIT_SLEEP = 0;
    localparam int BIT_AWAKE = 1;
    localparam int BIT_DFRZ  = 2;
    localparam int BIT_MRST  = 3;
    localparam int USED_BITS = 4;

endpackage

// File: rtl/canmode_rx_sync.sv
module canmode_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic wake_edge
);
    // chain[STAGES-1] is the synchronized line, chain[STAGES] its delayed copy
    logic [STAGES:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi <= STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= 1'b1;
                    else        chain[gi] <= rx_line;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[gi] <= 1'b1;
                    else        chain[gi] <= chain[gi-1];
                end
            end
        end
    endgenerate

    // recessive (1) to dominant (0) transition
    assign wake_edge = chain[STAGES] & ~chain[STAGES-1];

endmodule

// File: rtl/canmode_cfg_regs.sv
module canmode_cfg_regs
    import canmode_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             hw_wake_clr,
    output logic             mrst_req,
    output logic             sleep_req,
    output logic             auto_wake,
    output logic             dfrz_en
);
    assign mrst_req = wr & wdata[BIT_MRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sleep_req <= 1'b1;
            auto_wake <= 1'b0;
            dfrz_en   <= 1'b0;
        end else if (mrst_req) begin
            sleep_req <= 1'b1;
            auto_wake <= 1'b0;
            dfrz_en   <= 1'b0;
        end else begin
            if (wr) begin
                auto_wake <= wdata[BIT_AWAKE];
                dfrz_en   <= wdata[BIT_DFRZ];
            end
            if (hw_wake_clr)  sleep_req <= 1'b0;
            else if (wr)      sleep_req <= wdata[BIT_SLEEP];
        end
    end

endmodule

// File: rtl/canmode_fsm.sv
module canmode_fsm
    import canmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mrst_req,
    input  logic       sleep_req,
    input  logic       auto_wake,
    input  logic       dfrz_en,
    input  logic       dbg_halt,
    input  logic       frame_busy,
    input  logic       wake_edge,
    output logic       hw_wake_clr,
    output logic [1:0] mode,
    output logic       sleep_ack,
    output logic       eng_freeze,
    output logic       ctl_rst
);
    ctl_state_t state_q, state_d;
    logic       halt_frz;

    assign halt_frz = dfrz_en & dbg_halt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (mrst_req) begin
            state_d = ST_MRESET;
        end else begin
            unique case (state_q)
                ST_MRESET:     state_d = ST_SLEEP;
                ST_SLEEP:      if (!sleep_req || (auto_wake && wake_edge)) state_d = ST_NORMAL;
                ST_NORMAL:     if (sleep_req)      state_d = ST_SLEEP_WAIT;
                               else if (halt_frz)  state_d = ST_FROZEN;
                ST_SLEEP_WAIT: if (!sleep_req)     state_d = ST_NORMAL;
                               else if (!frame_busy) state_d = ST_SLEEP;
                ST_FROZEN:     if (!halt_frz)      state_d = ST_NORMAL;
                default:       state_d = ST_SLEEP;
            endcase
        end
    end

    always_comb begin
        mode        = MODE_NORMAL;
        sleep_ack   = 1'b0;
        eng_freeze  = 1'b0;
        ctl_rst     = 1'b0;
        hw_wake_clr = 1'b0;
        unique case (state_q)
            ST_MRESET: begin
                mode    = MODE_RESET;
                ctl_rst = 1'b1;
            end
            ST_SLEEP: begin
                mode        = MODE_SLEEP;
                sleep_ack   = 1'b1;
                hw_wake_clr = auto_wake & wake_edge & ~mrst_req;
            end
            ST_FROZEN: begin
                mode       = MODE_FROZEN;
                eng_freeze = 1'b1;
            end
            ST_NORMAL, ST_SLEEP_WAIT: mode = MODE_NORMAL;
            default: mode = MODE_NORMAL;
        endcase
    end

endmodule

// File: rtl/canmode_ctrl.sv
module canmode_ctrl
    import canmode_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             dbg_halt,
    input  logic             frame_busy,
    input  logic             rx_line,
    input  logic             fifo_rel_req,
    output logic             fifo_rel_go,
    output logic [1:0]       mode,
    output logic             sleep_ack,
    output logic             eng_freeze,
    output logic             ctl_rst
);
    localparam int RSV_W = CFG_W - USED_BITS;

    logic wake_edge, hw_wake_clr, mrst_req;
    logic sleep_req, auto_wake, dfrz_en;

    canmode_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .wake_edge (wake_edge)
    );

    canmode_cfg_regs #(.CFG_W(CFG_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (cfg_wr),
        .wdata       (cfg_wdata),
        .hw_wake_clr (hw_wake_clr),
        .mrst_req    (mrst_req),
        .sleep_req   (sleep_req),
        .auto_wake   (auto_wake),
        .dfrz_en     (dfrz_en)
    );

    canmode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mrst_req    (mrst_req),
        .sleep_req   (sleep_req),
        .auto_wake   (auto_wake),
        .dfrz_en     (dfrz_en),
        .dbg_halt    (dbg_halt),
        .frame_busy  (frame_busy),
        .wake_edge   (wake_edge),
        .hw_wake_clr (hw_wake_clr),
        .mode        (mode),
        .sleep_ack   (sleep_ack),
        .eng_freeze  (eng_freeze),
        .ctl_rst     (ctl_rst)
    );

    assign cfg_rdata[BIT_SLEEP] = sleep_req;
    assign cfg_rdata[BIT_AWAKE] = auto_wake;
    assign cfg_rdata[BIT_DFRZ]  = dfrz_en;
    assign cfg_rdata[BIT_MRST]  = ctl_rst;

    generate
        if (RSV_W > 0) begin : g_rsv
            assign cfg_rdata[CFG_W-1:USED_BITS] = '0;
        end
    endgenerate

    // FIFO access stays open while frozen; only the reset cycle blocks it
    assign fifo_rel_go = fifo_rel_req & ~ctl_rst;

endmodule

// File: rtl/canmode_ctrl_chk.sv
module canmode_ctrl_chk
    import canmode_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             dbg_halt,
    input logic             frame_busy,
    input logic             fifo_rel_req,
    input logic             fifo_rel_go,
    input logic [1:0]       mode,
    input logic             sleep_ack,
    input logic             eng_freeze,
    input logic             ctl_rst
);
    logic new_mrst;
    assign new_mrst = cfg_wr & cfg_wdata[BIT_MRST];

    AST_MRST_LANDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rst && !new_mrst) |=> (mode == MODE_SLEEP && sleep_ack && cfg_rdata[2:0] == 3'b001)); // R1

    AST_MRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rst && !new_mrst) |=> !cfg_rdata[BIT_MRST]); // R2

    AST_FREEZE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        eng_freeze |-> $past(dbg_halt)); // R3

    AST_FIFO_OPEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_freeze && fifo_rel_req) |-> fifo_rel_go); // R4

    AST_NO_FREEZE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[BIT_DFRZ] |=> !eng_freeze); // R5

    AST_SLEEP_HOLD_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ack && cfg_rdata[BIT_SLEEP] && !cfg_rdata[BIT_AWAKE] && !cfg_wr) |=> sleep_ack); // R6

    AST_HW_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sleep_ack) && $past(cfg_rdata[BIT_SLEEP]) && mode != MODE_RESET)
        |-> (!cfg_rdata[BIT_SLEEP] && mode == MODE_NORMAL)); // R7

    AST_ACK_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sleep_ack) && !$past(ctl_rst)) |-> !$past(frame_busy)); // R8

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[CFG_W-1:USED_BITS] == '0); // R9

endmodule

bind canmode_ctrl canmode_ctrl_chk #(.CFG_W(CFG_W)) u_chk (.*);

// File: tb/sim_canmode_ctrl.sv
module sim_canmode_ctrl;

    localparam int CFG_W = 8;
    localparam int NVEC  = 10;

    typedef struct packed {
        logic       wr;
        logic [7:0] wdata;
        logic       halt;
        logic       busy;
        logic       rx;
        logic [1:0] mode;
        logic       ack;
        logic       frz;
        logic [7:0] rd;
    } vec_t;

    // walk: wake sleep, freeze off/on, sleep with busy, manual-only sleep, hw wake
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 8'h00},
        '{1'b1, 8'h04, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1, 8'h04},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 8'h04},
        '{1'b1, 8'h01, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 8'h01},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 8'h01},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 8'h01},
        '{1'b1, 8'h03, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 8'h03},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h02},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 8'h02}
    };
    localparam string TAGS [NVEC] = '{"R6", "R5", "R3", "R3", "R8",
                                      "R8", "R6", "R6", "R7", "R7"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [CFG_W-1:0] cfg_rdata;
    logic             dbg_halt = 1'b0;
    logic             frame_busy = 1'b0;
    logic             rx_line = 1'b1;
    logic             fifo_rel_req = 1'b0;
    logic             fifo_rel_go;
    logic [1:0]       mode;
    logic             sleep_ack;
    logic             eng_freeze;
    logic             ctl_rst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    canmode_ctrl #(.CFG_W(CFG_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .dbg_halt     (dbg_halt),
        .frame_busy   (frame_busy),
        .rx_line      (rx_line),
        .fifo_rel_req (fifo_rel_req),
        .fifo_rel_go  (fifo_rel_go),
        .mode         (mode),
        .sleep_ack    (sleep_ack),
        .eng_freeze   (eng_freeze),
        .ctl_rst      (ctl_rst)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] val);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = val;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 power-on state
        check("R10", "mode", mode, 2'b01);
        check("R10", "sleep_ack", sleep_ack, 1'b1);
        check("R10", "freeze", eng_freeze, 1'b0);
        check("R10", "rdata", cfg_rdata, 8'h01);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            cfg_wr     = VECS[i].wr;
            cfg_wdata  = VECS[i].wdata;
            dbg_halt   = VECS[i].halt;
            frame_busy = VECS[i].busy;
            rx_line    = VECS[i].rx;
            @(negedge clk);
            cfg_wr = 1'b0;
            repeat (3) @(negedge clk);
            check(TAGS[i], $sformatf("vec%0d mode", i), mode, VECS[i].mode);
            check(TAGS[i], $sformatf("vec%0d ack", i), sleep_ack, VECS[i].ack);
            check(TAGS[i], $sformatf("vec%0d freeze", i), eng_freeze, VECS[i].frz);
            check(TAGS[i], $sformatf("vec%0d rdata", i), cfg_rdata, VECS[i].rd);
        end

        // R1 / R2: master reset, cycle by cycle
        write_cfg(8'h0E);
        check("R1", "reset mode", mode, 2'b11);
        check("R1", "ctl_rst", ctl_rst, 1'b1);
        check("R2", "mrst bit during reset", cfg_rdata, 8'h09);
        @(negedge clk);
        check("R1", "mode after reset", mode, 2'b01);
        check("R1", "ack after reset", sleep_ack, 1'b1);
        check("R1", "ctl_rst after", ctl_rst, 1'b0);
        check("R2", "rdata after reset", cfg_rdata, 8'h01);

        // R9: reserved bits ignore writes
        write_cfg(8'hF0);
        check("R9", "reserved read", cfg_rdata, 8'h00);

        // R4: FIFO release passes while frozen
        dbg_halt     = 1'b1;
        fifo_rel_req = 1'b1;
        write_cfg(8'h04);
        repeat (3) @(negedge clk);
        check("R4", "frozen", eng_freeze, 1'b1);
        check("R4", "release while frozen", fifo_rel_go, 1'b1);
        fifo_rel_req = 1'b0;
        dbg_halt     = 1'b0;

        // R8: sleep ack waits for the frame to end
        frame_busy = 1'b1;
        write_cfg(8'h01);
        repeat (4) @(negedge clk);
        check("R8", "ack held off", sleep_ack, 1'b0);
        check("R8", "mode while busy", mode, 2'b00);
        frame_busy = 1'b0;
        @(negedge clk);
        check("R8", "ack after idle", sleep_ack, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule